// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters on one input line and hands each finished character to a host-side holding register. Timing comes from an enable pulse running at sixteen times the bit rate. On each start edge the block counts sixteen of these pulses per bit. It takes a majority of three samples around the middle of each bit to decide the bit value. A character carries 8 or 9 data bits, least significant first, and ends with one stop bit. In 9-bit mode the extra bit is reported on its own output, next to the 8-bit data.

When a character is complete it is loaded into the holding register and a ready flag rises. While interrupts are enabled, that flag raises an interrupt request. Reading the register drops the flag. An overrun flag and a framing-error flag report a lost character and a bad stop bit.

For multi-drop links, software can put the receiver into standby. In standby the receiver keeps sampling the line but discards characters and raises no interrupt. It leaves standby in one of two ways, chosen by a select input:
- after the line has been high for one whole frame time;
- on a character whose top data bit is 1. That character is delivered to the host.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, rx_data, rx_bit8, data_ready, overrun, frame_err, standby and irq are all 0.
- R2: With nine_bit=0, a frame of one low start bit, 8 data bits sent least significant bit first and one stop bit loads the 8 data bits into rx_data, clears rx_bit8 and sets data_ready.
- R3: With nine_bit=1, a frame carries 9 data bits, least significant first: bits 0..7 go to rx_data and bit 8 goes to rx_bit8.
- R4: A low pulse on rxd that has returned high by sample 7 of the 16 samples after the falling edge is rejected as noise and delivers no character; the next valid frame is then received normally.
- R5: A stop bit sampled low still delivers the character, with frame_err=1; a high stop bit delivers it with frame_err=0.
- R6: If a character completes while data_ready is 1 and no read occurs in that cycle, overrun becomes 1 while rx_data and rx_bit8 keep the earlier character.
- R7: A one-cycle rd_strobe while data_ready is 1 clears data_ready, overrun and frame_err.
- R8: irq is 1 exactly when irq_en=1, data_ready=1 and standby=0, one cycle after these inputs settle.
- R9: A standby_req pulse sets standby. While in standby, irq is 0 and a character that does not wake the block leaves data_ready, overrun, frame_err, rx_data and rx_bit8 unchanged.
- R10: With wake_addr=1 in standby, a character whose most significant data bit is 1 clears standby and is delivered with data_ready set. That bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. With wake_addr=0, such a character neither wakes the block nor is delivered.
- R11: With wake_addr=0 in standby, the block clears standby once rxd has stayed high without interruption for one frame time since the standby request or the last low level. A frame time is 160 oversample ticks in 8-bit mode and 176 in 9-bit mode. With wake_addr=1, an idle line never clears standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idles high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | 1 wakes on a top data bit of 1, 0 wakes on an idle line |
| standby_req | input | 1 | One-cycle pulse that enters standby |
| irq_en | input | 1 | Enables the interrupt request |
| rd_strobe | input | 1 | One-cycle host read of the holding register |
| rx_data | output | 8 | Held character data bits 0..7 |
| rx_bit8 | output | 1 | Held ninth data bit (0 in 8-bit mode) |
| data_ready | output | 1 | A character is held and unread |
| overrun | output | 1 | A character was lost because the register was full |
| frame_err | output | 1 | The held character had a low stop bit |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest cases to reach are the standby corners. The idle wakeup must fire exactly at the frame-length boundary and not a few ticks earlier. Characters received in standby must leave every held value untouched. To reach these, the stimulus issues a standby request on an already idle line and then samples standby a few cycles before and after 160 and 176 ticks. It sends frames in standby whose top bit is 0 and 1, under both wake selections and both lengths, and then reads the held state back through the normal outputs. Random characters, lengths and oversample rates are mixed with these directed cases, along with a short noise pulse and back-to-back frames for overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR    = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(OSR);
    localparam int MID    = OSR / 2;
    localparam int IDX_W  = $clog2(DATA_W + 1);
    localparam int IDLE_W = $clog2(OSR * (DATA_W + 3) + 1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } samp_state_e;

    typedef struct packed {
        logic valid;
        logic value;
        logic is_stop;
        logic nine;
    } bit_evt_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              bit8;
        logic              addr_mark;
        logic              stop_bad;
    } frame_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(input logic nine);
        return nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    endfunction

    function automatic logic [IDLE_W-1:0] idle_ticks(input logic nine);
        return nine ? IDLE_W'(OSR * (DATA_W + 3)) : IDLE_W'(OSR * (DATA_W + 2));
    endfunction

endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     nine_bit,
    output bit_evt_t evt
);

    samp_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             s_a;
    logic             s_b;
    logic             nine_q;
    logic             mid_vote;

    assign mid_vote = vote3(s_a, s_b, rx_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cnt         <= '0;
            idx         <= '0;
            s_a         <= 1'b1;
            s_b         <= 1'b1;
            nine_q      <= 1'b0;
            evt.valid   <= 1'b0;
            evt.value   <= 1'b0;
            evt.is_stop <= 1'b0;
            evt.nine    <= 1'b0;
        end else begin
            evt.valid <= 1'b0;
            if (tick) begin
                if (state == S_IDLE) begin
                    if (!rx_s) begin
                        state  <= S_START;
                        cnt    <= CNT_W'(1);
                        nine_q <= nine_bit;
                    end
                end else begin
                    cnt <= (cnt == CNT_W'(OSR - 1)) ? '0 : cnt + CNT_W'(1);
                    if (cnt == CNT_W'(MID - 1)) s_a <= rx_s;
                    if (cnt == CNT_W'(MID))     s_b <= rx_s;
                    if (cnt == CNT_W'(MID + 1)) begin
                        case (state)
                            S_START: if (mid_vote) state <= S_IDLE;
                            S_DATA: begin
                                evt.valid   <= 1'b1;
                                evt.value   <= mid_vote;
                                evt.is_stop <= 1'b0;
                                evt.nine    <= nine_q;
                            end
                            S_STOP: begin
                                evt.valid   <= 1'b1;
                                evt.value   <= mid_vote;
                                evt.is_stop <= 1'b1;
                                evt.nine    <= nine_q;
                                state       <= S_IDLE;
                            end
                            default: state <= S_IDLE;
                        endcase
                    end
                    if (cnt == CNT_W'(OSR - 1)) begin
                        if (state == S_START) begin
                            state <= S_DATA;
                            idx   <= '0;
                        end else if (state == S_DATA) begin
                            if (idx == last_idx(nine_q)) state <= S_STOP;
                            else                         idx   <= idx + IDX_W'(1);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rx_frame_shifter.sv
module rx_frame_shifter
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    output frame_t   frm
);

    logic [DATA_W:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh            <= '0;
            frm.valid     <= 1'b0;
            frm.data      <= '0;
            frm.bit8      <= 1'b0;
            frm.addr_mark <= 1'b0;
            frm.stop_bad  <= 1'b0;
        end else begin
            frm.valid <= 1'b0;
            if (evt.valid && !evt.is_stop) begin
                sh <= {evt.value, sh[DATA_W:1]};
            end else if (evt.valid) begin
                frm.valid     <= 1'b1;
                frm.stop_bad  <= ~evt.value;
                frm.addr_mark <= sh[DATA_W];
                if (evt.nine) begin
                    frm.data <= sh[DATA_W-1:0];
                    frm.bit8 <= sh[DATA_W];
                end else begin
                    frm.data <= sh[DATA_W:1];
                    frm.bit8 <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect
    import uart_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_s,
    input  logic nine_bit,
    input  logic clear,
    output logic idle_hit
);

    logic [IDLE_W-1:0] run;
    logic [IDLE_W-1:0] limit;

    assign limit = idle_ticks(nine_bit);

    always_ff @(posedge clk) begin
        if (rst || clear || !rx_s) begin
            run      <= '0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= tick && (run == limit - IDLE_W'(1));
            if (tick && run < limit) run <= run + IDLE_W'(1);
        end
    end

endmodule

// File: rtl/rx_hold_flags.sv
module rx_hold_flags
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frm,
    input  logic              idle_hit,
    input  logic              wake_addr,
    input  logic              standby_req,
    input  logic              rd_strobe,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              data_ready,
    output logic              overrun,
    output logic              frame_err,
    output logic              standby,
    output logic              irq
);

    logic addr_wake;
    logic idle_wake;
    logic deliver;
    logic rd_hit;

    assign addr_wake = standby & wake_addr & frm.valid & frm.addr_mark;
    assign idle_wake = standby & ~wake_addr & idle_hit;
    assign deliver   = frm.valid & (~standby | addr_wake);
    assign rd_hit    = rd_strobe & data_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            rx_bit8    <= 1'b0;
            data_ready <= 1'b0;
            overrun    <= 1'b0;
            frame_err  <= 1'b0;
            standby    <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (rd_hit) begin
                data_ready <= 1'b0;
                overrun    <= 1'b0;
                frame_err  <= 1'b0;
            end
            if (deliver) begin
                if (data_ready && !rd_strobe) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data    <= frm.data;
                    rx_bit8    <= frm.bit8;
                    data_ready <= 1'b1;
                    frame_err  <= frm.stop_bad;
                end
            end
            if (standby_req)                 standby <= 1'b1;
            else if (addr_wake || idle_wake) standby <= 1'b0;
            irq <= irq_en & data_ready & ~standby;
        end
    end

endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       nine_bit,
    input  logic       wake_addr,
    input  logic       standby_req,
    input  logic       irq_en,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       data_ready,
    output logic       overrun,
    output logic       frame_err,
    output logic       standby,
    output logic       irq
);

    logic [1:0] sync_q;
    logic       rx_s;
    bit_evt_t   evt;
    frame_t     frm;
    logic       idle_hit;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end
    assign rx_s = sync_q[1];

    rx_bit_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rx_s     (rx_s),
        .nine_bit (nine_bit),
        .evt      (evt)
    );

    rx_frame_shifter u_shifter (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .frm (frm)
    );

    rx_idle_detect u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rx_s     (rx_s),
        .nine_bit (nine_bit),
        .clear    (standby_req),
        .idle_hit (idle_hit)
    );

    rx_hold_flags u_hold (
        .clk         (clk),
        .rst         (rst),
        .frm         (frm),
        .idle_hit    (idle_hit),
        .wake_addr   (wake_addr),
        .standby_req (standby_req),
        .rd_strobe   (rd_strobe),
        .irq_en      (irq_en),
        .rx_data     (rx_data),
        .rx_bit8     (rx_bit8),
        .data_ready  (data_ready),
        .overrun     (overrun),
        .frame_err   (frame_err),
        .standby     (standby),
        .irq         (irq)
    );

endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       standby_req,
    input logic       wake_addr,
    input logic       frm_valid,
    input logic       frm_mark,
    input logic       idle_hit,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       overrun,
    input logic       standby,
    input logic       irq
);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && data_ready && !frm_valid) |=> !data_ready);

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && data_ready && !standby && !rd_strobe) |=> (overrun && $stable(rx_data)));

    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (standby && $past(standby)) |=> !irq);

    assert_standby_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (standby && frm_valid && !(wake_addr && frm_mark) && !rd_strobe)
        |=> ($stable(data_ready) && $stable(rx_data) && $stable(overrun)));

    assert_addr_wake_R10: assert property (@(posedge clk) disable iff (rst)
        (standby && wake_addr && frm_valid && frm_mark && !standby_req)
        |=> (!standby && data_ready));

    assert_idle_wake_R11: assert property (@(posedge clk) disable iff (rst)
        (standby && !wake_addr && idle_hit && !standby_req) |=> !standby);

    assert_irq_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        !data_ready |=> !irq);

endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_strobe   (rd_strobe),
    .standby_req (standby_req),
    .wake_addr   (wake_addr),
    .frm_valid   (frm.valid),
    .frm_mark    (frm.addr_mark),
    .idle_hit    (idle_hit),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .overrun     (overrun),
    .standby     (standby),
    .irq         (irq)
);

// File: tb/uart_rx_wake_bench.sv
`timescale 1ns/1ps
module uart_rx_wake_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic       wake_addr = 1'b0;
    logic       standby_req = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic       data_ready;
    logic       overrun;
    logic       frame_err;
    logic       standby;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int tcnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tcnt <= (tcnt >= div - 1) ? 0 : tcnt + 1;
    assign tick16 = (tcnt == 0);

    uart_rx_wake u_uart_rx_wake (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .nine_bit(nine_bit),
        .wake_addr(wake_addr), .standby_req(standby_req), .irq_en(irq_en),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .data_ready(data_ready), .overrun(overrun), .frame_err(frame_err),
        .standby(standby), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data(input logic [8:0] v);
        return v[7:0];
    endfunction

    function automatic logic exp_bit8(input logic [8:0] v, input logic nine);
        return nine ? v[8] : 1'b0;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        wait_cyc(16 * div);
    endtask

    task automatic send_frame(input logic [8:0] v, input logic nine, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) send_bit(v[i]);
        send_bit(stop);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        wait_cyc(1);
        rd_strobe = 1'b0;
        wait_cyc(2);
    endtask

    task automatic enter_standby();
        standby_req = 1'b1;
        wait_cyc(1);
        standby_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [8:0] v;
        logic       nine;
        void'($urandom(32'd1234));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        check("R1 rx_data", rx_data, 0);
        check("R1 flags", {rx_bit8, data_ready, overrun, frame_err, standby, irq}, 0);

        irq_en = 1'b1;
        // R2 directed 8-bit
        send_frame(9'h0A5, 1'b0, 1'b1);
        check("R2 data", rx_data, 8'hA5);
        check("R2 ready", data_ready, 1);
        check("R2 bit8", rx_bit8, 0);
        check("R5 clean stop", frame_err, 0);
        check("R8 irq on", irq, 1);
        do_read();
        check("R7 ready cleared", data_ready, 0);
        check("R8 irq off", irq, 0);

        // R3 directed 9-bit
        nine_bit = 1'b1;
        send_frame(9'h13C, 1'b1, 1'b1);
        check("R3 data", rx_data, 8'h3C);
        check("R3 bit8", rx_bit8, 1);
        do_read();

        // R2 R3 random characters, lengths and tick rates
        for (int k = 0; k < 20; k++) begin
            v = 9'($urandom);
            nine = 1'($urandom);
            div = 1 + int'($urandom % 2);
            nine_bit = nine;
            send_frame(v, nine, 1'b1);
            check(nine ? "R3 rand data" : "R2 rand data", rx_data, exp_data(v));
            check(nine ? "R3 rand bit8" : "R2 rand bit8", rx_bit8, exp_bit8(v, nine));
            check("R2 rand ready", data_ready, 1);
            do_read();
        end
        div = 1;
        nine_bit = 1'b0;
        wait_cyc(4);

        // R4 noise pulse
        rxd = 1'b0;
        wait_cyc(5);
        rxd = 1'b1;
        wait_cyc(60);
        check("R4 noise ignored", data_ready, 0);
        send_frame(9'h05A, 1'b0, 1'b1);
        check("R4 recovery data", rx_data, 8'h5A);
        check("R4 recovery ready", data_ready, 1);
        do_read();

        // R5 framing error
        send_frame(9'h033, 1'b0, 1'b0);
        check("R5 frame_err", frame_err, 1);
        check("R5 data kept", rx_data, 8'h33);
        do_read();
        check("R7 frame_err cleared", frame_err, 0);

        // R6 overrun
        send_frame(9'h011, 1'b0, 1'b1);
        send_frame(9'h022, 1'b0, 1'b1);
        check("R6 data kept", rx_data, 8'h11);
        check("R6 overrun", overrun, 1);
        do_read();
        check("R7 overrun cleared", overrun, 0);
        check("R7 ready after overrun", data_ready, 0);

        // R8 irq enable gating
        irq_en = 1'b0;
        send_frame(9'h044, 1'b0, 1'b1);
        check("R8 irq masked", irq, 0);
        irq_en = 1'b1;
        wait_cyc(3);
        check("R8 irq enabled", irq, 1);

        // R9 standby suppresses irq and discards characters
        enter_standby();
        wake_addr = 1'b1;
        wait_cyc(3);
        check("R9 standby set", standby, 1);
        check("R9 irq quiet", irq, 0);
        check("R9 ready kept", data_ready, 1);
        send_frame(9'h012, 1'b0, 1'b1);
        check("R9 data unchanged", rx_data, 8'h44);
        check("R9 no overrun", overrun, 0);
        check("R9 still standby", standby, 1);
        do_read();
        send_frame(9'h013, 1'b0, 1'b0);
        check("R9 discarded ready", data_ready, 0);
        check("R9 discarded frame_err", frame_err, 0);
        check("R9 discarded data", rx_data, 8'h44);

        // R10 address-mark wake, 8-bit (bit 7)
        send_frame(9'h09C, 1'b0, 1'b1);
        check("R10 woke 8-bit", standby, 0);
        check("R10 data 8-bit", rx_data, 8'h9C);
        check("R10 ready 8-bit", data_ready, 1);
        do_read();

        // R10 9-bit: bit 7 alone does not mark, bit 8 does
        nine_bit = 1'b1;
        enter_standby();
        send_frame(9'h0FF, 1'b1, 1'b1);
        check("R10 9-bit bit7 no wake", standby, 1);
        check("R10 9-bit no delivery", data_ready, 0);
        send_frame(9'h105, 1'b1, 1'b1);
        check("R10 9-bit woke", standby, 0);
        check("R10 9-bit data", rx_data, 8'h05);
        check("R10 9-bit bit8", rx_bit8, 1);
        do_read();

        // R10 idle mode ignores address marks
        nine_bit = 1'b0;
        wake_addr = 1'b0;
        enter_standby();
        send_frame(9'h080, 1'b0, 1'b1);
        check("R10 idle mode mark ignored", standby, 1);
        check("R10 idle mode no delivery", data_ready, 0);

        // R11 idle wake, 8-bit: 160 ticks
        enter_standby();
        wait_cyc(150);
        check("R11 8-bit early", standby, 1);
        wait_cyc(20);
        check("R11 8-bit woke", standby, 0);

        // R11 idle wake, 9-bit: 176 ticks
        nine_bit = 1'b1;
        enter_standby();
        wait_cyc(170);
        check("R11 9-bit early", standby, 1);
        wait_cyc(15);
        check("R11 9-bit woke", standby, 0);

        // R11 address mode never wakes on idle
        nine_bit = 1'b0;
        wake_addr = 1'b1;
        enter_standby();
        wait_cyc(400);
        check("R11 addr mode idle ignored", standby, 1);
        send_frame(9'h080, 1'b0, 1'b1);
        check("R10 final wake", standby, 0);
        do_read();

        done = 1;
        finish_run();
    end

endmodule